// File: doc/BRIEF.md
# Matrix LRU Way Selector

This block tracks access recency for the ways of one set of an N-way set-associative cache. Recency is kept as an N×N bit matrix of pairwise orderings: entry [a][b] is 1 when way b has been used more recently than way a. The matrix is stored as a flat vector with entry [a][b] at bit a*N+b.

When the cache controller reports a hit, the accessed way becomes the newest. Its row is cleared and its column is set. The diagonal is never written and reads 0.

Two one-hot vectors are derived from the stored matrix, with the diagonal treated as 1:
- The column reduction names the most recently used way. After an update it equals the accessed way.
- The row reduction names the least recently used way. The refill logic takes this way as its victim.

Hits count in the read, refill and invalidate controller states. In the idle state they are ignored.

Top module: `lru_set_tracker`

## Requirements
- R1: After a clock edge with `rst_n` low, matrix entry [a][b] (bit a*N+b) is 1 exactly when b < a. `mru_way` is then way 0 (bit 0) and `victim_way` is way N-1 (bit N-1).
- R2: A qualifying access to way i takes effect at the next rising clock edge and is visible at the outputs right after it. It clears every entry [i][j] with j≠i and sets every entry [j][i] with j≠i. All other entries keep their values.
- R3: When `hit_way` has more than one bit set, only the highest-numbered set way is applied, as a single index, to both the row and the column update.
- R4: Bit i of `mru_way` is the AND of column i of the stored matrix, with the diagonal taken as 1. After a qualifying access it equals the one-hot code of the accessed way.
- R5: Bit i of `victim_way` is the AND of row i of the stored matrix, with the diagonal taken as 1. It names the way whose most recent access is the oldest.
- R6: `victim_way` and `mru_way` each have exactly one bit set in every cycle after reset.
- R7: Hits count as accesses when `ctrl_state` is 1 (read), 2 (refill) or 3 (invalidate). With `ctrl_state` 0 (idle), a hit leaves the matrix unchanged.
- R8: With `hit_valid` low, or with `hit_way` all zero, the matrix is left unchanged.
- R9: Diagonal entries [i][i] always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_state | input | 2 | Controller state: 0 idle, 1 read, 2 refill, 3 invalidate |
| hit_valid | input | 1 | A hit is reported this cycle |
| hit_way | input | NUM_WAYS | One-hot way that was hit |
| matrix_q | output | NUM_WAYS*NUM_WAYS | Stored order matrix, entry [a][b] at bit a*N+b |
| mru_way | output | NUM_WAYS | One-hot most recently used way |
| victim_way | output | NUM_WAYS | One-hot least recently used way (refill victim) |

## Verification
The matrix is the only state, so every result of a hit is due exactly one rising edge after the hit is driven: one register stage, with both one-hot outputs combinational from it.

The bench drives each stimulus on a falling edge. It lets one rising edge pass and compares matrix, MRU and victim on the following falling edge, before the next stimulus is applied.

Expected values come from a recency list kept in the bench. The expected matrix is rebuilt from the ranks in that list.

The sweep covers every combination of controller state, valid flag and 4-bit hit pattern, so ignored hits and multi-bit patterns are checked in the same cycle slot as the real updates.

// File: rtl/lru_mat_pkg.sv
// Package: shared types for the matrix LRU selector.
// Assumes the controller state is carried as a 2-bit code.
package lru_mat_pkg;
    typedef enum logic [1:0] {
        CST_IDLE   = 2'd0,
        CST_READ   = 2'd1,
        CST_REFILL = 2'd2,
        CST_INVAL  = 2'd3
    } ctrl_st_e;
endpackage

// File: rtl/lru_way_index.sv
// Module: lru_way_index
// Converts an access vector to one way index; the highest set bit wins.
// Assumes NUM_WAYS >= 2.
module lru_way_index #(
    parameter int NUM_WAYS = 4,
    localparam int IDXW = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] acc_vec,
    output logic [IDXW-1:0]     acc_idx,
    output logic                acc_any
);
    // Scan upward so the last (highest) set bit overrides earlier ones.
    always_comb begin
        acc_idx = '0;
        acc_any = 1'b0;
        for (int k = 0; k < NUM_WAYS; k++) begin
            if (acc_vec[k]) begin
                acc_idx = IDXW'(k);
                acc_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lru_matrix_update.sv
// Module: lru_matrix_update
// Computes the next order matrix: the accessed row is cleared and the
// accessed column is set. The diagonal is passed through unchanged.
// Assumes entry [a][b] is stored at bit a*NUM_WAYS+b.
module lru_matrix_update #(
    parameter int NUM_WAYS = 4,
    localparam int IDXW = $clog2(NUM_WAYS),
    localparam int MW   = NUM_WAYS * NUM_WAYS
) (
    input  logic [MW-1:0]   cur_mat,
    input  logic [IDXW-1:0] acc_idx,
    input  logic            acc_en,
    output logic [MW-1:0]   nxt_mat
);
    for (genvar a = 0; a < NUM_WAYS; a++) begin : g_row
        for (genvar b = 0; b < NUM_WAYS; b++) begin : g_col
            if (a == b) begin : g_diag
                // Diagonal bits are never written.
                assign nxt_mat[a*NUM_WAYS+b] = cur_mat[a*NUM_WAYS+b];
            end else begin : g_off
                // Row of the accessed way goes low; its column goes high.
                always_comb begin
                    if (acc_en && acc_idx == IDXW'(a))
                        nxt_mat[a*NUM_WAYS+b] = 1'b0;
                    else if (acc_en && acc_idx == IDXW'(b))
                        nxt_mat[a*NUM_WAYS+b] = 1'b1;
                    else
                        nxt_mat[a*NUM_WAYS+b] = cur_mat[a*NUM_WAYS+b];
                end
            end
        end
    end
endmodule

// File: rtl/lru_order_reduce.sv
// Module: lru_order_reduce
// Reduces the order matrix to a newest-way vector (column AND) and an
// oldest-way vector (row AND), with the diagonal treated as 1.
module lru_order_reduce #(
    parameter int NUM_WAYS = 4,
    localparam int MW = NUM_WAYS * NUM_WAYS
) (
    input  logic [MW-1:0]       mat,
    output logic [NUM_WAYS-1:0] col_all,
    output logic [NUM_WAYS-1:0] row_all
);
    for (genvar k = 0; k < NUM_WAYS; k++) begin : g_way
        // AND the off-diagonal entries of column k and of row k.
        always_comb begin
            col_all[k] = 1'b1;
            row_all[k] = 1'b1;
            for (int j = 0; j < NUM_WAYS; j++) begin
                if (j != k) begin
                    col_all[k] = col_all[k] & mat[j*NUM_WAYS+k];
                    row_all[k] = row_all[k] & mat[k*NUM_WAYS+j];
                end
            end
        end
    end
endmodule

// File: rtl/lru_set_tracker.sv
// Module: lru_set_tracker
// Holds the recency matrix for one cache set. Hits in the read, refill
// and invalidate states update it; idle-state hits are ignored.
// Assumes a synchronous active-low reset and 2 <= NUM_WAYS <= 8.
module lru_set_tracker
    import lru_mat_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int IDXW = $clog2(NUM_WAYS),
    localparam int MW   = NUM_WAYS * NUM_WAYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ctrl_state,
    input  logic                hit_valid,
    input  logic [NUM_WAYS-1:0] hit_way,
    output logic [MW-1:0]       matrix_q,
    output logic [NUM_WAYS-1:0] mru_way,
    output logic [NUM_WAYS-1:0] victim_way
);
    ctrl_st_e            st;
    logic                st_counts;
    logic [NUM_WAYS-1:0] acc_vec;
    logic [IDXW-1:0]     acc_idx;
    logic                acc_any;
    logic [MW-1:0]       nxt_mat;
    logic [MW-1:0]       reset_pat;

    // Decide whether the controller state lets a hit update the matrix.
    always_comb begin
        st        = ctrl_st_e'(ctrl_state);
        st_counts = (st == CST_READ) || (st == CST_REFILL) || (st == CST_INVAL);
        acc_vec   = (hit_valid && st_counts) ? hit_way : '0;
    end

    // Reset order: lower-numbered ways count as newer.
    for (genvar a = 0; a < NUM_WAYS; a++) begin : g_rst_row
        for (genvar b = 0; b < NUM_WAYS; b++) begin : g_rst_col
            assign reset_pat[a*NUM_WAYS+b] = (b < a) ? 1'b1 : 1'b0;
        end
    end

    lru_way_index #(.NUM_WAYS(NUM_WAYS)) u_index (
        .acc_vec (acc_vec),
        .acc_idx (acc_idx),
        .acc_any (acc_any)
    );

    lru_matrix_update #(.NUM_WAYS(NUM_WAYS)) u_update (
        .cur_mat (matrix_q),
        .acc_idx (acc_idx),
        .acc_en  (acc_any),
        .nxt_mat (nxt_mat)
    );

    lru_order_reduce #(.NUM_WAYS(NUM_WAYS)) u_reduce (
        .mat     (matrix_q),
        .col_all (mru_way),
        .row_all (victim_way)
    );

    // Matrix register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            matrix_q <= reset_pat;
        else
            matrix_q <= nxt_mat;
    end

    // R6: exactly one victim and one newest way.
    a_r6_onehot_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($onehot(victim_way) && $onehot(mru_way)));

    // R7: idle-state hits leave the matrix untouched.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == 2'd0) |=> $stable(matrix_q));

    // R8: no valid hit, no change.
    a_r8_novalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_valid || hit_way == '0) |=> $stable(matrix_q));

    // R4: a single-way access becomes the newest way.
    a_r4_mru_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && ctrl_state != 2'd0 && $onehot(hit_way)) |=> (mru_way == $past(hit_way)));

    // R5: the just-accessed way is never the victim.
    a_r5_victim_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && ctrl_state != 2'd0 && $onehot(hit_way)) |=> ((victim_way & $past(hit_way)) == '0));
endmodule

// File: tb/lru_set_tracker_bench.sv
`timescale 1ns/1ps
module lru_set_tracker_bench;
    localparam int NW = 4;
    localparam int MW = NW * NW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    ctrl_state;
    logic          hit_valid;
    logic [NW-1:0] hit_way;
    logic [MW-1:0] matrix_q;
    logic [NW-1:0] mru_way;
    logic [NW-1:0] victim_way;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int order [NW];   // order[0] newest ... order[NW-1] oldest

    always #4 clk = ~clk;

    lru_set_tracker #(.NUM_WAYS(NW)) u_lru_set_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_state (ctrl_state),
        .hit_valid  (hit_valid),
        .hit_way    (hit_way),
        .matrix_q   (matrix_q),
        .mru_way    (mru_way),
        .victim_way (victim_way)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] model_mat();
        logic [MW-1:0] m = '0;
        int rk [NW];
        for (int p = 0; p < NW; p++) rk[order[p]] = p;
        for (int a = 0; a < NW; a++)
            for (int b = 0; b < NW; b++)
                if (a != b && rk[b] < rk[a]) m[a*NW+b] = 1'b1;
        return m;
    endfunction

    task automatic compare_all(input string mreq);
        logic [MW-1:0] diag = '0;
        check(mreq, 64'(matrix_q), 64'(model_mat()));
        check("R4", 64'(mru_way), 64'(1 << order[0]));
        check("R5", 64'(victim_way), 64'(1 << order[NW-1]));
        check("R6", 64'({$onehot(mru_way), $onehot(victim_way)}), 64'd3);
        for (int k = 0; k < NW; k++) diag[k*NW+k] = matrix_q[k*NW+k];
        check("R9", 64'(diag), 64'd0);
    endtask

    // Drive one stimulus, let one rising edge pass, compare on next falling edge.
    task automatic step(input int st, input bit v, input logic [NW-1:0] w);
        string req;
        int idx = -1;
        ctrl_state = 2'(st);
        hit_valid  = v;
        hit_way    = w;
        for (int k = 0; k < NW; k++) if (w[k]) idx = k;
        if (st != 0 && v && idx >= 0) begin
            int pos = 0;
            for (int p = 0; p < NW; p++) if (order[p] == idx) pos = p;
            for (int p = pos; p > 0; p--) order[p] = order[p-1];
            order[0] = idx;
            req = ($countones(w) > 1) ? "R3" : "R2";
        end else if (st == 0) begin
            req = "R7";
        end else begin
            req = "R8";
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        rst_n      = 1'b0;
        ctrl_state = 2'd0;
        hit_valid  = 1'b0;
        hit_way    = '0;
        for (int k = 0; k < NW; k++) order[k] = k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");
        // Exhaustive sweep over state, valid and hit pattern, twice.
        for (int rnd = 0; rnd < 2; rnd++)
            for (int st = 0; st < 4; st++)
                for (int v = 0; v < 2; v++)
                    for (int w = 0; w < (1 << NW); w++)
                        step((st + rnd) % 4, v[0], NW'(w));
        // Reverse walk, then ignored hits must not disturb it.
        for (int w = NW - 1; w >= 0; w--) step(2, 1'b1, NW'(1 << w));
        step(0, 1'b1, NW'(1 << (NW - 1)));
        step(3, 1'b1, '0);
        // Reset again mid-run returns the fixed order.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NW; k++) order[k] = k;
        compare_all("R1");
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule